// File: doc/BRIEF.md
# CAN Transmitter Protection Controller

This block sits between a host controller's transmit and receive pins and the driver and receiver of a CAN physical layer. The host transmit line is active low: low means dominant and high means recessive. In normal operation a dominant host bit turns the bus driver on, and the digitized receiver result is passed back to the host receive pin. All inputs are asynchronous to the block clock. Each one passes through a two-flop synchronizer before any logic uses it.

The block implements three protections, and every delay is counted in clock cycles.

- **Dominant timeout guard.** It arms on each falling edge of the transmit line. It shuts the driver off when the line stays dominant too long. It stays latched off until the line returns recessive.
- **Over-temperature gate.** It removes drive for as long as the thermal flag is set.
- **Supply supervisor.** It watches the logic-side and bus-side supply flags. It tri-states the receive pin when the logic side is lost. It forces the receive pin to a failsafe high a set time after the bus side is lost. After both supplies return, it waits a resume delay before normal operation starts again.

Top module: `can_tx_protect`

## Requirements
- R1: In normal operation, `drv_en_o` is 1 exactly when the synchronized `host_tx_i` is 0 (dominant), and `rxd_o` equals `bus_rx_i`. Both outputs follow their inputs 3 clock edges after an input change.
- R2: After a falling edge of `host_tx_i`, if the line stays 0, `drv_en_o` is 1 for exactly `TIMEOUT_CYC` consecutive cycles and then goes to 0.
- R3: After a timeout, `drv_en_o` stays 0 while `host_tx_i` stays 0. Once `host_tx_i` has been 1, the next falling edge drives the bus again.
- R4: A dominant pulse shorter than `TIMEOUT_CYC` never trips the guard. The driver is enabled for as many cycles as the pulse lasts.
- R5: During a dominant timeout and during over-temperature, `rxd_o` keeps following `bus_rx_i`.
- R6: While `overtemp_i` is 1, `drv_en_o` is 0, starting 3 edges after the flag rises. Drive resumes 3 edges after the flag clears, provided the host is still dominant and no timeout has occurred.
- R7: The driver is enabled only when both supply flags have been good through the resume delay.
- R8: When `logic_pwr_ok_i` is 0, `rxd_oe_o` goes to 0 four edges after the drop, and `drv_en_o` stays 0.
- R9: When `bus_pwr_ok_i` drops while the logic supply is good, `drv_en_o` goes to 0. `rxd_o` keeps following the bus through edge `FAILSAFE_CYC`+3 and is 1 from edge `FAILSAFE_CYC`+4.
- R10: When both supplies become good again, `rxd_o` is held at 1 through edge `RESUME_CYC`+3. Normal operation starts at edge `RESUME_CYC`+4.
- R11: During reset, `drv_en_o`=0, `rxd_o`=1 and `rxd_oe_o`=1, and the timeout latch is cleared. After reset is released, `rxd_o` stays 1 through edge `RESUME_CYC` and follows the bus from edge `RESUME_CYC`+1. The transmit line is taken as recessive before reset, so a line held low through reset arms the guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_tx_i | input | 1 | Host transmit bit, 0 = dominant |
| bus_rx_i | input | 1 | Receiver comparator result, 0 = dominant |
| logic_pwr_ok_i | input | 1 | Logic-side supply good |
| bus_pwr_ok_i | input | 1 | Bus-side supply good |
| overtemp_i | input | 1 | Over-temperature flag |
| drv_en_o | output | 1 | Bus driver enable |
| rxd_o | output | 1 | Receive data to host |
| rxd_oe_o | output | 1 | Output enable for the receive pin |

## Verification
- **Stuck timeout latch.** A latch that stays set would keep `drv_en_o` at 0 after the host has gone recessive and dominant again. This is visible within 3 edges of the next falling edge.
- **Off-by-one timeout counter.** An error here changes the number of cycles the driver is on during a long dominant stretch, so counting enabled cycles exposes it exactly.
- **Wrong supply state.** A supply state that is entered too early or too late moves the cycle at which `rxd_o` switches to failsafe high or back to the bus value. Checking both sides of each boundary edge catches this.
- **Wrong gating.** A fault in the enable gating shows within 3 edges as drive during over-temperature, during logic-supply loss or during failsafe.

// File: rtl/can_prot_pkg.sv
package can_prot_pkg;

    typedef enum logic [2:0] {
        PS_RESUME   = 3'd0,
        PS_RUN      = 3'd1,
        PS_BUSWAIT  = 3'd2,
        PS_FAILSAFE = 3'd3,
        PS_LOGICOFF = 3'd4
    } pwr_state_e;

    // Synchronizer lane positions
    localparam int LANE_TX  = 0;
    localparam int LANE_RX  = 1;
    localparam int LANE_LOK = 2;
    localparam int LANE_BOK = 3;
    localparam int LANE_OT  = 4;
    localparam int LANES    = 5;

endpackage

// File: rtl/cp_sync_bank.sv
module cp_sync_bank #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cp_dom_guard.sv
module cp_dom_guard #(
    parameter int TIMEOUT_CYC = 22500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_s,
    output logic trip_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] LIM = TW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic          tx_prev;
        logic          run;
        logic          trip;
        logic [TW-1:0] cnt;
    } guard_t;

    guard_t g_d, g_q;

    always_comb begin
        g_d         = g_q;
        g_d.tx_prev = tx_s;
        if (tx_s) begin
            g_d.run  = 1'b0;
            g_d.trip = 1'b0;
            g_d.cnt  = '0;
        end else if (g_q.tx_prev) begin
            g_d.run = 1'b1;
            g_d.cnt = TW'(1);
        end else if (g_q.run) begin
            if (g_q.cnt == LIM) begin
                g_d.run  = 1'b0;
                g_d.trip = 1'b1;
            end else begin
                g_d.cnt = g_q.cnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{tx_prev: 1'b1, run: 1'b0, trip: 1'b0, cnt: '0};
        end else begin
            g_q <= g_d;
        end
    end

    assign trip_o = g_q.trip;

    AST_TRIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.trip && tx_s) |=> !g_q.trip); // R3
    AST_TRIP_ONLY_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_q.trip) |-> !$past(tx_s)); // R2
endmodule

// File: rtl/cp_supply_fsm.sv
module cp_supply_fsm
    import can_prot_pkg::*;
#(
    parameter int FAILSAFE_CYC = 300,
    parameter int RESUME_CYC   = 15000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lok_s,
    input  logic       bok_s,
    output pwr_state_e state_o
);
    localparam int MAXC = (FAILSAFE_CYC > RESUME_CYC) ? FAILSAFE_CYC : RESUME_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] FS_LIM = CW'(FAILSAFE_CYC - 1);
    localparam logic [CW-1:0] RS_LIM = CW'(RESUME_CYC - 1);

    typedef struct packed {
        pwr_state_e    st;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (!lok_s) begin
            f_d.st  = PS_LOGICOFF;
            f_d.cnt = '0;
        end else if (!bok_s) begin
            case (f_q.st)
                PS_RUN: begin
                    f_d.st  = PS_BUSWAIT;
                    f_d.cnt = '0;
                end
                PS_BUSWAIT: begin
                    if (f_q.cnt == FS_LIM) f_d.st = PS_FAILSAFE;
                    else                   f_d.cnt = f_q.cnt + CW'(1);
                end
                default: begin
                    f_d.st  = PS_FAILSAFE;
                    f_d.cnt = '0;
                end
            endcase
        end else begin
            case (f_q.st)
                PS_RUN: f_d.st = PS_RUN;
                PS_RESUME: begin
                    if (f_q.cnt == RS_LIM) f_d.st = PS_RUN;
                    else                   f_d.cnt = f_q.cnt + CW'(1);
                end
                default: begin
                    f_d.st  = PS_RESUME;
                    f_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{st: PS_RESUME, cnt: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign state_o = f_q.st;

    AST_RUN_NEEDS_SUPPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == PS_RUN) |-> $past(lok_s && bok_s)); // R7
    AST_LOGIC_LOSS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !lok_s |=> (f_q.st == PS_LOGICOFF)); // R8
endmodule

// File: rtl/can_tx_protect.sv
module can_tx_protect
    import can_prot_pkg::*;
#(
    parameter int TIMEOUT_CYC  = 22500,
    parameter int FAILSAFE_CYC = 300,
    parameter int RESUME_CYC   = 15000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_tx_i,
    input  logic bus_rx_i,
    input  logic logic_pwr_ok_i,
    input  logic bus_pwr_ok_i,
    input  logic overtemp_i,
    output logic drv_en_o,
    output logic rxd_o,
    output logic rxd_oe_o
);
    localparam logic [LANES-1:0] SYNC_RST = 5'b0_1_1_1_1;

    logic [LANES-1:0] raw, syn;
    logic             tx_s, rx_s, lok_s, bok_s, ot_s;
    logic             trip;
    pwr_state_e       pstate;

    assign raw[LANE_TX]  = host_tx_i;
    assign raw[LANE_RX]  = bus_rx_i;
    assign raw[LANE_LOK] = logic_pwr_ok_i;
    assign raw[LANE_BOK] = bus_pwr_ok_i;
    assign raw[LANE_OT]  = overtemp_i;

    cp_sync_bank #(.W(LANES), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    assign tx_s  = syn[LANE_TX];
    assign rx_s  = syn[LANE_RX];
    assign lok_s = syn[LANE_LOK];
    assign bok_s = syn[LANE_BOK];
    assign ot_s  = syn[LANE_OT];

    cp_dom_guard #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_s   (tx_s),
        .trip_o (trip)
    );

    cp_supply_fsm #(.FAILSAFE_CYC(FAILSAFE_CYC), .RESUME_CYC(RESUME_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .lok_s   (lok_s),
        .bok_s   (bok_s),
        .state_o (pstate)
    );

    typedef struct packed {
        logic drv;
        logic rxd;
        logic oe;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d.drv = (pstate == PS_RUN) && !tx_s && !trip && !ot_s;
        o_d.rxd = ((pstate == PS_RUN) || (pstate == PS_BUSWAIT)) ? rx_s : 1'b1;
        o_d.oe  = (pstate != PS_LOGICOFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '{drv: 1'b0, rxd: 1'b1, oe: 1'b1};
        end else begin
            o_q <= o_d;
        end
    end

    assign drv_en_o = o_q.drv;
    assign rxd_o    = o_q.rxd;
    assign rxd_oe_o = o_q.oe;

    AST_HOT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ot_s |=> !drv_en_o); // R6
    AST_TRIP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> !drv_en_o); // R3
    AST_FAILSAFE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_FAILSAFE) |=> rxd_o); // R9
    AST_LOGIC_LOSS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !lok_s |=> ##1 !rxd_oe_o); // R8
    AST_RECESSIVE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_s |=> !drv_en_o); // R1
endmodule

// File: tb/can_tx_protect_test.sv
module can_tx_protect_test;
    localparam int T_CYC = 40;
    localparam int F_CYC = 8;
    localparam int R_CYC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_tx = 1'b1, bus_rx = 1'b0, lok = 1'b1, bok = 1'b1, ot = 1'b0;
    logic drv_en, rxd, rxd_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    can_tx_protect #(.TIMEOUT_CYC(T_CYC), .FAILSAFE_CYC(F_CYC), .RESUME_CYC(R_CYC)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_tx_i      (host_tx),
        .bus_rx_i       (bus_rx),
        .logic_pwr_ok_i (lok),
        .bus_pwr_ok_i   (bok),
        .overtemp_i     (ot),
        .drv_en_o       (drv_en),
        .rxd_o          (rxd),
        .rxd_oe_o       (rxd_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // {tx, rx, ot, exp_drv, exp_rxd}
    localparam logic [4:0] VEC [8] = '{
        5'b1_0_0_0_0, 5'b0_0_0_1_0, 5'b1_1_0_0_1, 5'b0_1_0_1_1,
        5'b1_1_1_0_1, 5'b0_1_1_0_1, 5'b1_0_1_0_0, 5'b0_0_1_0_0
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        // R11 reset state
        tick(3);
        chk("R11 drv in reset", drv_en, 1'b0);
        chk("R11 rxd in reset", rxd, 1'b1);
        chk("R11 oe in reset", rxd_oe, 1'b1);
        rst_n = 1'b1;
        tick(R_CYC);
        chk("R11 rxd held before resume end", rxd, 1'b1);
        tick(1);
        chk("R11 rxd follows after resume", rxd, 1'b0);

        // R1 R5 R6 vector table
        foreach (VEC[i]) begin
            host_tx = VEC[i][4];
            bus_rx  = VEC[i][3];
            ot      = VEC[i][2];
            tick(4);
            chk("R1 R6 vector drv", drv_en, VEC[i][1]);
            chk("R1 R5 vector rxd", rxd, VEC[i][0]);
            chk("R1 vector oe", rxd_oe, 1'b1);
        end
        host_tx = 1'b1; ot = 1'b0; bus_rx = 1'b0;
        tick(6);

        // R1 latency
        host_tx = 1'b0;
        tick(2);
        chk("R1 drv not yet", drv_en, 1'b0);
        tick(1);
        chk("R1 drv at edge 3", drv_en, 1'b1);
        host_tx = 1'b1;
        tick(6);

        // R2 exact timeout count
        host_tx = 1'b0;
        cnt = 0;
        for (int i = 0; i < 3 * T_CYC; i++) begin
            tick(1);
            if (drv_en) cnt++;
            if (i == 2 * T_CYC) bus_rx = 1'b1;
        end
        chk_int("R2 enabled cycles", cnt, T_CYC);
        chk("R3 latched off", drv_en, 1'b0);
        chk("R5 rxd during timeout", rxd, 1'b1);
        bus_rx = 1'b0;
        tick(4);
        chk("R5 rxd follows during timeout", rxd, 1'b0);
        host_tx = 1'b1;
        tick(4);
        host_tx = 1'b0;
        tick(3);
        chk("R3 drive after recessive", drv_en, 1'b1);
        host_tx = 1'b1;
        tick(6);

        // R4 short pulses
        cnt = 0;
        for (int p = 0; p < 5; p++) begin
            host_tx = 1'b0;
            for (int i = 0; i < 10; i++) begin tick(1); if (drv_en) cnt++; end
            host_tx = 1'b1;
            for (int i = 0; i < 10; i++) begin tick(1); if (drv_en) cnt++; end
        end
        chk_int("R4 short pulse cycles", cnt, 50);

        // R6 over-temperature timing
        host_tx = 1'b0;
        tick(3);
        chk("R6 driving before hot", drv_en, 1'b1);
        ot = 1'b1;
        tick(2);
        chk("R6 still on at edge 2", drv_en, 1'b1);
        tick(1);
        chk("R6 off when hot", drv_en, 1'b0);
        bus_rx = 1'b1;
        tick(3);
        chk("R5 rxd during hot", rxd, 1'b1);
        ot = 1'b0;
        tick(3);
        chk("R6 restored after cool", drv_en, 1'b1);
        host_tx = 1'b1; bus_rx = 1'b0;
        tick(6);

        // R9 bus supply loss
        bok = 1'b0;
        tick(4);
        chk("R9 drv off on bus loss", drv_en, 1'b0);
        tick(F_CYC - 1);
        chk("R9 rxd follows before failsafe", rxd, 1'b0);
        tick(1);
        chk("R9 failsafe high", rxd, 1'b1);
        host_tx = 1'b0;
        tick(4);
        chk("R7 no drive in failsafe", drv_en, 1'b0);
        host_tx = 1'b1;
        tick(4);

        // R10 resume delay
        bok = 1'b1;
        tick(R_CYC + 3);
        chk("R10 held during resume", rxd, 1'b1);
        tick(1);
        chk("R10 normal after resume", rxd, 1'b0);

        // R8 logic supply loss
        host_tx = 1'b0;
        lok = 1'b0;
        tick(3);
        chk("R8 oe before edge 4", rxd_oe, 1'b1);
        tick(1);
        chk("R8 oe off", rxd_oe, 1'b0);
        chk("R8 drv off", drv_en, 1'b0);
        host_tx = 1'b1;
        lok = 1'b1;
        tick(4);
        chk("R8 oe restored", rxd_oe, 1'b1);
        tick(R_CYC + 2);
        chk("R10 resume after logic loss", rxd, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule